// File: doc/BRIEF.md
# Register Write Width Extension Unit

This unit sits on the write port of a register file whose registers always match the address width of the core (16, 32 or 64 bits). A load delivers an operand that is 8, 16, 32 or 64 bits wide. The unit merges that operand with the register's present contents and produces the full-width value to be written back. A two-bit mode input chooses what fills the bits above the operand. The choices are clearing, keeping the old bits, replicating the operand's top bit, or setting them to one. Clearing is the default mode.

A request whose operand is wider than the implemented register must not reach the register file. For such a request the unit holds the write enable low and raises an abort request instead. A parameter selects whether the results leave the unit directly or through one register stage.

Top module: `rwx_unit`

## Requirements
- R1: `size_code` selects the operand width: 00 = 8, 01 = 16, 10 = 32, 11 = 64 bits. On an accepted write, the low operand-width bits of `wr_data` equal the same bits of `operand`.
- R2: With `ext_mode` 00 (zero fill), every `wr_data` bit above the operand width is 0.
- R3: With `ext_mode` 01 (keep), every `wr_data` bit above the operand width equals the same bit of `reg_cur`.
- R4: With `ext_mode` 10 (sign fill), every `wr_data` bit above the operand width equals operand bit (width-1).
- R5: With `ext_mode` 11 (ones fill), every `wr_data` bit above the operand width is 1.
- R6: When the operand width equals REG_W, `ext_mode` has no effect and `wr_data` equals the low REG_W bits of `operand`.
- R7: When `wr_req` is high and the operand width exceeds REG_W, `wide_abort` is 1 and `wr_en` is 0.
- R8: When the operand width is at most REG_W, `wr_en` follows `wr_req` and `wide_abort` is 0. When `wr_req` is low, both `wr_en` and `wide_abort` are 0.
- R9: With REG_OUT = 1, the outputs appear one clock after their inputs, and reset (`rst_n` low) drives all outputs to 0. With REG_OUT = 0, the outputs follow the inputs in the same cycle.
- R10: Operand bits at or above the operand width do not affect `wr_data`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the optional output stage |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_req | input | 1 | Register write requested this cycle |
| size_code | input | 2 | Operand width code |
| ext_mode | input | 2 | Upper-bit fill mode |
| operand | input | 64 | Loaded operand value (low bits significant) |
| reg_cur | input | REG_W | Current register contents |
| wr_en | output | 1 | Write enable to the register file |
| wr_data | output | REG_W | New full-width register value |
| wide_abort | output | 1 | Abort request for an over-wide operation |

## Verification
The bench sweeps every size code against every fill mode, with two configurations running side by side: a 16-bit direct-output unit and a 32-bit registered unit. The operand patterns give both values of the top operand bit at each width, so a sign fill taken from the wrong bit position shows up as a wrong upper half. The equal-width case is covered, where a unit that wrongly applied the fill would corrupt the top bits. The over-wide case is covered, where a unit that let the write through would assert `wr_en`. Garbage above the operand width exposes a merge that leaks the upper operand bits. The cycle sampling of the registered unit catches an output stage that is missing or doubled.

// File: rtl/rwx_pkg.sv
package rwx_pkg;

    localparam int MAX_W = 64;

    typedef enum logic [1:0] {
        SZ_8  = 2'b00,
        SZ_16 = 2'b01,
        SZ_32 = 2'b10,
        SZ_64 = 2'b11
    } size_e;

    typedef enum logic [1:0] {
        EXT_ZERO = 2'b00,
        EXT_KEEP = 2'b01,
        EXT_SIGN = 2'b10,
        EXT_ONES = 2'b11
    } ext_e;

    // Operand width in bits for a size code.
    function automatic logic [31:0] size_bits(input logic [1:0] code);
        return 32'd8 << code;
    endfunction

    // Mask covering the operand bits for a size code.
    function automatic logic [MAX_W-1:0] lane_mask(input logic [1:0] code);
        unique case (size_e'(code))
            SZ_8:    return 64'h0000_0000_0000_00FF;
            SZ_16:   return 64'h0000_0000_0000_FFFF;
            SZ_32:   return 64'h0000_0000_FFFF_FFFF;
            default: return '1;
        endcase
    endfunction

endpackage

// File: rtl/rwx_width_check.sv
module rwx_width_check
    import rwx_pkg::*;
#(
    parameter int REG_W = 64
) (
    input  logic       wr_req,
    input  logic [1:0] size_code,
    output logic       wr_en,
    output logic       wide_abort
);

    logic too_wide;

    always_comb begin
        too_wide   = size_bits(size_code) > 32'(REG_W);
        wide_abort = wr_req && too_wide;
        wr_en      = wr_req && !too_wide;
    end

endmodule

// File: rtl/rwx_merge.sv
module rwx_merge
    import rwx_pkg::*;
#(
    parameter int REG_W = 64
) (
    input  logic [MAX_W-1:0] operand,
    input  logic [REG_W-1:0] reg_cur,
    input  logic [1:0]       size_code,
    input  logic [1:0]       ext_mode,
    output logic [REG_W-1:0] data
);

    logic [31:0]      width_bits;
    logic             top_bit;
    logic [REG_W-1:0] fill_v;

    always_comb begin
        width_bits = size_bits(size_code);
        unique case (size_e'(size_code))
            SZ_8:    top_bit = operand[7];
            SZ_16:   top_bit = operand[15];
            SZ_32:   top_bit = operand[31];
            default: top_bit = operand[63];
        endcase
        unique case (ext_e'(ext_mode))
            EXT_ZERO: fill_v = '0;
            EXT_KEEP: fill_v = reg_cur;
            EXT_SIGN: fill_v = {REG_W{top_bit}};
            default:  fill_v = '1;
        endcase
    end

    for (genvar i = 0; i < REG_W; i++) begin : g_bit
        assign data[i] = (32'(i) < width_bits) ? operand[i] : fill_v[i];
    end

endmodule

// File: rtl/rwx_out_stage.sv
module rwx_out_stage #(
    parameter int REG_W   = 64,
    parameter bit REG_OUT = 1'b1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en_in,
    input  logic             abort_in,
    input  logic [REG_W-1:0] data_in,
    output logic             en_out,
    output logic             abort_out,
    output logic [REG_W-1:0] data_out
);

    if (REG_OUT) begin : g_reg
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                en_out    <= 1'b0;
                abort_out <= 1'b0;
                data_out  <= '0;
            end else begin
                en_out    <= en_in;
                abort_out <= abort_in;
                data_out  <= data_in;
            end
        end
    end else begin : g_pass
        assign en_out    = en_in;
        assign abort_out = abort_in;
        assign data_out  = data_in;
    end

endmodule

// File: rtl/rwx_unit.sv
module rwx_unit
    import rwx_pkg::*;
#(
    parameter int REG_W   = 64,
    parameter bit REG_OUT = 1'b1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_req,
    input  logic [1:0]       size_code,
    input  logic [1:0]       ext_mode,
    input  logic [63:0]      operand,
    input  logic [REG_W-1:0] reg_cur,
    output logic             wr_en,
    output logic [REG_W-1:0] wr_data,
    output logic             wide_abort
);

    logic             en_c;
    logic             abort_c;
    logic [REG_W-1:0] data_c;

    rwx_width_check #(.REG_W(REG_W)) chk_i (
        .wr_req     (wr_req),
        .size_code  (size_code),
        .wr_en      (en_c),
        .wide_abort (abort_c)
    );

    rwx_merge #(.REG_W(REG_W)) merge_i (
        .operand   (operand),
        .reg_cur   (reg_cur),
        .size_code (size_code),
        .ext_mode  (ext_mode),
        .data      (data_c)
    );

    rwx_out_stage #(.REG_W(REG_W), .REG_OUT(REG_OUT)) stage_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .en_in     (en_c),
        .abort_in  (abort_c),
        .data_in   (data_c),
        .en_out    (wr_en),
        .abort_out (wide_abort),
        .data_out  (wr_data)
    );

    logic [REG_W-1:0] low_m;
    assign low_m = lane_mask(size_code)[REG_W-1:0];

    a_r7_abort_blocks_write: assert property (@(posedge clk) disable iff (!rst_n)
        wide_abort |-> !wr_en);

    a_r8_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_req |-> (!en_c && !abort_c));

    a_r1_low_bits: assert property (@(posedge clk) disable iff (!rst_n)
        en_c |-> (((data_c ^ operand[REG_W-1:0]) & low_m) == '0));

    a_r2_zero_upper: assert property (@(posedge clk) disable iff (!rst_n)
        (en_c && ext_mode == 2'b00) |-> ((data_c & ~low_m) == '0));

    a_r3_keep_upper: assert property (@(posedge clk) disable iff (!rst_n)
        (en_c && ext_mode == 2'b01) |-> (((data_c ^ reg_cur) & ~low_m) == '0));

    a_r5_ones_upper: assert property (@(posedge clk) disable iff (!rst_n)
        (en_c && ext_mode == 2'b11) |-> ((data_c | low_m) == '1));

    if (REG_OUT) begin : g_a_reg
        a_r9_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
            $past(rst_n) |-> (wr_data == $past(data_c) && wr_en == $past(en_c)));
    end

endmodule

// File: tb/rwx_unit_tb_top.sv
`timescale 1ns/1ps
module rwx_unit_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_req = 1'b0;
    logic [1:0]  size_code = 2'b00;
    logic [1:0]  ext_mode = 2'b00;
    logic [63:0] operand = '0;
    logic [63:0] cur64 = '0;

    logic        en_r, abort_r, en_c, abort_c;
    logic [31:0] data_r;
    logic [15:0] data_c;

    int checks = 0;
    int errors = 0;

    always #2 clk = ~clk;

    rwx_unit #(.REG_W(32), .REG_OUT(1'b1)) dut_i (
        .clk(clk), .rst_n(rst_n), .wr_req(wr_req), .size_code(size_code),
        .ext_mode(ext_mode), .operand(operand), .reg_cur(cur64[31:0]),
        .wr_en(en_r), .wr_data(data_r), .wide_abort(abort_r)
    );

    rwx_unit #(.REG_W(16), .REG_OUT(1'b0)) dut_c_i (
        .clk(clk), .rst_n(rst_n), .wr_req(wr_req), .size_code(size_code),
        .ext_mode(ext_mode), .operand(operand), .reg_cur(cur64[15:0]),
        .wr_en(en_c), .wr_data(data_c), .wide_abort(abort_c)
    );

    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %h expected %h", tag, act, exp);
        end
    endtask

    function automatic logic [63:0] model(input int s, input int m,
                                          input logic [63:0] op, input logic [63:0] cur);
        int w = 8 << s;
        logic [63:0] mask = (w == 64) ? '1 : ((64'd1 << w) - 64'd1);
        logic [63:0] fill;
        case (m)
            0: fill = '0;
            1: fill = cur;
            2: fill = op[w-1] ? '1 : '0;
            default: fill = '1;
        endcase
        return (op & mask) | (fill & ~mask);
    endfunction

    function automatic string tag_of(input int s, input int m, input int rw);
        int w = 8 << s;
        if (w > rw) return "R7";
        if (w == rw) return "R6 R1";
        case (m)
            0: return "R2 R1 R10";
            1: return "R3 R1 R10";
            2: return "R4 R1 R10";
            default: return "R5 R1 R10";
        endcase
    endfunction

    initial begin
        #(4 * 200000);
        errors++;
        checks++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [63:0] ops [4];
        logic [63:0] curs [2];
        ops[0] = 64'h0123_4567_89AB_CDEF;
        ops[1] = 64'hFEDC_BA98_7654_3210;
        ops[2] = 64'h8080_8080_8080_8080;
        ops[3] = 64'h7F7F_7F7F_7F7F_7F7F;
        curs[0] = 64'hA5A5_A5A5_A5A5_A5A5;
        curs[1] = 64'h3C3C_3C3C_3C3C_3C3C;

        // R9: reset holds the registered outputs at zero
        wr_req = 1'b1; operand = ops[0]; cur64 = curs[0];
        repeat (3) @(posedge clk);
        #1;
        check("R9 reset en", {63'd0, en_r}, 64'd0);
        check("R9 reset data", {32'd0, data_r}, 64'd0);
        check("R9 reset abort", {63'd0, abort_r}, 64'd0);
        @(negedge clk);
        rst_n = 1'b1;

        for (int s = 0; s < 4; s++) begin
            for (int m = 0; m < 4; m++) begin
                for (int o = 0; o < 4; o++) begin
                    for (int c = 0; c < 2; c++) begin
                        for (int q = 0; q < 2; q++) begin
                            @(negedge clk);
                            size_code = 2'(s); ext_mode = 2'(m);
                            operand = ops[o]; cur64 = curs[c]; wr_req = q[0];
                            @(posedge clk);
                            #1;
                            // 16-bit direct-output unit (R9 same cycle)
                            check({"R8 en16 ", tag_of(s, m, 16)}, {63'd0, en_c},
                                  {63'd0, q[0] && (8 << s) <= 16});
                            check({"R7 abort16 ", tag_of(s, m, 16)}, {63'd0, abort_c},
                                  {63'd0, q[0] && (8 << s) > 16});
                            if (q[0] && (8 << s) <= 16)
                                check({"data16 ", tag_of(s, m, 16)}, {48'd0, data_c},
                                      {48'd0, model(s, m, ops[o], curs[c])[15:0]});
                            // 32-bit registered unit (R9 one cycle later)
                            check({"R9 en32 ", tag_of(s, m, 32)}, {63'd0, en_r},
                                  {63'd0, q[0] && (8 << s) <= 32});
                            check({"R7 abort32 ", tag_of(s, m, 32)}, {63'd0, abort_r},
                                  {63'd0, q[0] && (8 << s) > 32});
                            if (q[0] && (8 << s) <= 32)
                                check({"R9 data32 ", tag_of(s, m, 32)}, {32'd0, data_r},
                                      {32'd0, model(s, m, ops[o], curs[c])[31:0]});
                        end
                    end
                end
            end
        end

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule